// File: doc/BRIEF.md
# Virtual Address Translator with Table Walker

This block sits between a processor and physical memory and turns virtual addresses into physical ones. A request carries a virtual address and an access kind (load, store or instruction fetch). The address is split into a page offset, which passes straight through, and a virtual page number, which is looked up in a small fully associative cache of recent translations. On a hit the answer comes back one cycle after the request is taken. On a miss the block computes where the page-table entry sits in memory, reads it through a simple read port, checks it, and answers.

Every table entry carries a present flag, a two-bit permission code and a physical page number. A missing page yields a page fault and a disallowed access kind yields a protection fault. Neither kind of faulting entry is kept in the cache. The table's starting address is held in a base register written from outside. Writing that register, or pulsing the flush input, empties the cache so that mappings from a previous address space cannot be reused. While a walk is in flight the block holds `busy` high and ignores new requests.

Top module: `xlate_unit`

## Requirements
- R1: A translated physical address is `{ppn, offset}`: the low 10 bits (1 KB pages) of the virtual address appear unchanged as the low 10 bits of `rsp_paddr`.
- R2: A request taken while `busy` is low and whose page is cached gets `rsp_valid` on the next cycle, with no memory read and with `busy` staying low.
- R3: On a miss, exactly one `mem_rd_en` pulse is issued on the next cycle at address `base + 4*VPN`, `busy` is high from that cycle until the response, and `rsp_valid` follows one cycle after `mem_rd_valid`.
- R4: A table entry is a 32-bit word: bit 31 is the present flag, bits 30:29 the permission code, bits PPN_W-1:0 the physical page number.
- R5: An entry with bit 31 at 0 yields `rsp_fault` = 1 (page fault), `rsp_paddr` = 0, and is not cached, so the next request to that page walks again.
- R6: Access kinds are 0 load, 1 store, 2 fetch. Permission codes are 0 read-only (load), 1 read/write (load, store), 2 execute (fetch), 3 no access. A disallowed kind yields `rsp_fault` = 2 and `rsp_paddr` = 0, both on a cache hit and after a walk.
- R7: A walk that ends with `rsp_fault` = 0 installs the entry, and a later request to the same page hits.
- R8: An install goes to the lowest-numbered empty slot. If none is empty, it goes to the least recently used slot. Hits and installs both make a slot most recently used.
- R9: `base_wr_en` loads `base_wr_data` into the base register and empties the cache. Later walks use the new base.
- R10: `flush` empties the cache. A request taken in the same cycle as `flush` or `base_wr_en` is treated as a miss. A walk whose data returns in such a cycle still answers but is not installed.
- R11: After reset, `busy`, `rsp_valid` and `mem_rd_en` are 0, the cache is empty and the base register is 0.
- R12: `req_valid` while `busy` is high is ignored: no extra read and no extra response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| busy | output | 1 | A table walk is in flight |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PPN_W+10 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_rd_en | output | 1 | Table read request pulse |
| mem_rd_addr | output | PPN_W+10 | Physical address of the table entry |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Table entry word |
| base_wr_en | input | 1 | Write the table base register |
| base_wr_data | input | PPN_W+10 | New table base address |
| flush | input | 1 | Empty the translation cache |

## Verification
Cache invalidation (flush or base write) can fall in the same cycle as a lookup or as the return of a walk. The bench provokes both: it raises `flush` together with `req_valid` for a page it knows to be cached, and it raises `flush` in the same cycle as `mem_rd_valid` for a walk that would otherwise install. It judges them at the ports: the first must show a memory read instead of a hit, and the second must answer with the walked translation while a repeat request to that page walks again.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGT_RO   = 2'd0,
        RGT_RW   = 2'd1,
        RGT_EXEC = 2'd2,
        RGT_NONE = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2,
        FLT_RSVD = 2'd3
    } fault_e;

    typedef enum logic {
        ST_LOOK = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;

    // table entry word layout
    localparam int PTE_W         = 32;
    localparam int PTE_BYTES     = 4;
    localparam int PTE_VALID_POS = 31;
    localparam int PTE_RGT_LSB   = 29;

    function automatic logic rights_allow(rights_e r, acc_kind_e k);
        logic ok;
        case (r)
            RGT_RO:   ok = (k == ACC_LOAD);
            RGT_RW:   ok = (k == ACC_LOAD) || (k == ACC_STORE);
            RGT_EXEC: ok = (k == ACC_FETCH);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlate_perm.sv
module xlate_perm
    import xlate_pkg::*;
(
    input  logic       pte_vld,
    input  logic [1:0] pte_rgt,
    input  logic [1:0] kind,
    output logic [1:0] fault
);
    fault_e f;

    always_comb begin
        if (!pte_vld)
            f = FLT_PAGE;
        else if (!rights_allow(rights_e'(pte_rgt), acc_kind_e'(kind)))
            f = FLT_PROT;
        else
            f = FLT_NONE;
    end

    assign fault = f;
endmodule

// File: rtl/xlate_tags.sv
module xlate_tags #(
    parameter  int ENTRIES = 8,
    parameter  int VPN_W   = 22,
    parameter  int PPN_W   = 20,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               inval,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PPN_W-1:0]   ins_ppn,
    input  logic [1:0]         ins_rgt,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [1:0]         hit_rgt,
    output logic [ENTRIES-1:0] vld_vec
);
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_arr [ENTRIES];
    logic [PPN_W-1:0]   ppn_arr [ENTRIES];
    logic [1:0]         rgt_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic             vld_r;
        logic [VPN_W-1:0] vpn_r;
        logic [PPN_W-1:0] ppn_r;
        logic [1:0]       rgt_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_r <= 1'b0;
                vpn_r <= '0;
                ppn_r <= '0;
                rgt_r <= '0;
            end else if (inval) begin
                vld_r <= 1'b0;
            end else if (ins_en && (ins_idx == IDX_W'(g))) begin
                vld_r <= 1'b1;
                vpn_r <= ins_vpn;
                ppn_r <= ins_ppn;
                rgt_r <= ins_rgt;
            end
        end

        assign match[g]   = vld_r && (vpn_r == lk_vpn);
        assign vld_vec[g] = vld_r;
        assign vpn_arr[g] = vpn_r;
        assign ppn_arr[g] = ppn_r;
        assign rgt_arr[g] = rgt_r;
    end

    always_comb begin
        hit_idx = '0;
        hit_ppn = '0;
        hit_rgt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                hit_ppn = ppn_arr[i];
                hit_rgt = rgt_arr[i];
            end
        end
    end

    assign hit = |match;

    logic unused_vpn_view;
    assign unused_vpn_view = ^vpn_arr[0];

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R10
    inval_empty_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (vld_vec == '0));
endmodule

// File: rtl/xlate_age.sv
module xlate_age #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] vld_vec,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0]   age_arr [ENTRIES];
    logic [ENTRIES-1:0] oldest;
    logic [IDX_W-1:0]   touch_age;

    assign touch_age = age_arr[touch_idx];

    // age 0 is most recent, ENTRIES-1 is the eviction candidate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        logic [IDX_W-1:0] age_r;

        always_ff @(posedge clk) begin
            if (rst)
                age_r <= IDX_W'(g);
            else if (touch_en) begin
                if (touch_idx == IDX_W'(g))
                    age_r <= '0;
                else if (age_r < touch_age)
                    age_r <= age_r + 1'b1;
            end
        end

        assign age_arr[g] = age_r;
        assign oldest[g]  = (age_r == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest[i])
                    victim = IDX_W'(i);
            end
        end
    end

    // R8
    age_order_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest));

    // R8
    fresh_touch_chk: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (age_arr[$past(touch_idx)] == '0));
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
    import xlate_pkg::*;
#(
    parameter  int ENTRIES    = 8,
    parameter  int VA_W       = 32,
    parameter  int PPN_W      = 20,
    parameter  int PAGE_BYTES = 1024,
    localparam int OFS_W      = $clog2(PAGE_BYTES),
    localparam int PA_W       = PPN_W + OFS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    output logic            busy,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_fault,
    output logic            mem_rd_en,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic            base_wr_en,
    input  logic [PA_W-1:0] base_wr_data,
    input  logic            flush
);
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int PTE_SH = $clog2(PTE_BYTES);
    localparam int SUM_W  = ((PA_W > VPN_W + PTE_SH) ? PA_W : VPN_W + PTE_SH) + 1;

    walk_st_e         st_q;
    logic [PA_W-1:0]  base_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFS_W-1:0] ofs_q;
    logic [1:0]       kind_q;
    logic             rsp_valid_q;
    logic [PA_W-1:0]  rsp_paddr_q;
    logic [1:0]       rsp_fault_q;
    logic             mem_en_q;
    logic [PA_W-1:0]  mem_addr_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFS_W-1:0] req_ofs;
    logic             inval;
    logic             accept;
    logic             hit_raw, hit_use;
    logic [IDX_W-1:0] hit_idx, victim;
    logic [PPN_W-1:0] hit_ppn;
    logic [1:0]       hit_rgt;
    logic [ENTRIES-1:0] vld_vec;
    logic [1:0]       hit_fault, walk_fault;
    logic             walk_done, install, touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic             pte_vld;
    logic [1:0]       pte_rgt;
    logic [PPN_W-1:0] pte_ppn;
    logic [SUM_W-1:0] tbl_sum;

    assign req_vpn = req_vaddr[VA_W-1:OFS_W];
    assign req_ofs = req_vaddr[OFS_W-1:0];
    assign inval   = flush || base_wr_en;
    assign accept  = req_valid && (st_q == ST_LOOK);
    assign hit_use = hit_raw && !inval;

    assign pte_vld = mem_rd_data[PTE_VALID_POS];
    assign pte_rgt = mem_rd_data[PTE_RGT_LSB +: 2];
    assign pte_ppn = mem_rd_data[PPN_W-1:0];

    logic unused_pte_bits;
    assign unused_pte_bits = ^mem_rd_data[PTE_RGT_LSB-1:PPN_W];

    assign tbl_sum = SUM_W'(base_q) + (SUM_W'(req_vpn) << PTE_SH);

    assign walk_done = (st_q == ST_WALK) && mem_rd_valid;
    assign install   = walk_done && (fault_e'(walk_fault) == FLT_NONE) && !inval;
    assign touch_en  = (accept && hit_use) || install;
    assign touch_idx = install ? victim : hit_idx;

    xlate_tags #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_vpn  (req_vpn),
        .inval   (inval),
        .ins_en  (install),
        .ins_idx (victim),
        .ins_vpn (vpn_q),
        .ins_ppn (pte_ppn),
        .ins_rgt (pte_rgt),
        .hit     (hit_raw),
        .hit_idx (hit_idx),
        .hit_ppn (hit_ppn),
        .hit_rgt (hit_rgt),
        .vld_vec (vld_vec)
    );

    xlate_age #(.ENTRIES(ENTRIES)) u_age (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .vld_vec   (vld_vec),
        .victim    (victim)
    );

    xlate_perm u_perm_hit (
        .pte_vld (1'b1),
        .pte_rgt (hit_rgt),
        .kind    (req_kind),
        .fault   (hit_fault)
    );

    xlate_perm u_perm_walk (
        .pte_vld (pte_vld),
        .pte_rgt (pte_rgt),
        .kind    (kind_q),
        .fault   (walk_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_LOOK;
            base_q      <= '0;
            vpn_q       <= '0;
            ofs_q       <= '0;
            kind_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_paddr_q <= '0;
            rsp_fault_q <= '0;
            mem_en_q    <= 1'b0;
            mem_addr_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            mem_en_q    <= 1'b0;
            if (base_wr_en)
                base_q <= base_wr_data;
            case (st_q)
                ST_LOOK: begin
                    if (accept) begin
                        vpn_q  <= req_vpn;
                        ofs_q  <= req_ofs;
                        kind_q <= req_kind;
                        if (hit_use) begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= hit_fault;
                            rsp_paddr_q <= (fault_e'(hit_fault) == FLT_NONE)
                                           ? {hit_ppn, req_ofs} : '0;
                        end else begin
                            st_q       <= ST_WALK;
                            mem_en_q   <= 1'b1;
                            mem_addr_q <= tbl_sum[PA_W-1:0];
                        end
                    end
                end
                ST_WALK: begin
                    if (mem_rd_valid) begin
                        st_q        <= ST_LOOK;
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= walk_fault;
                        rsp_paddr_q <= (fault_e'(walk_fault) == FLT_NONE)
                                       ? {pte_ppn, ofs_q} : '0;
                    end
                end
                default: st_q <= ST_LOOK;
            endcase
        end
    end

    assign busy        = (st_q == ST_WALK);
    assign rsp_valid   = rsp_valid_q;
    assign rsp_paddr   = rsp_paddr_q;
    assign rsp_fault   = rsp_fault_q;
    assign mem_rd_en   = mem_en_q;
    assign mem_rd_addr = mem_addr_q;

    // R3
    read_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

    // R3
    walk_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_rd_en);

    // R2
    rsp_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    // R5
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault != 2'd0)) |-> (rsp_paddr == '0));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd_valid) |=> (busy && !rsp_valid));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault == 2'd0)) |-> (rsp_paddr[OFS_W-1:0] == ofs_q));
endmodule

// File: tb/xlate_unit_tb.sv
module xlate_unit_tb;
    localparam int NE   = 8;
    localparam int VA_W = 32;
    localparam int PPNW = 20;
    localparam int PAW  = PPNW + 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0]      req_kind = '0;
    logic            busy, rsp_valid, mem_rd_en;
    logic [PAW-1:0]  rsp_paddr, mem_rd_addr;
    logic [1:0]      rsp_fault;
    logic            mem_rd_valid = 1'b0;
    logic [31:0]     mem_rd_data = '0;
    logic            base_wr_en = 1'b0;
    logic [PAW-1:0]  base_wr_data = '0;
    logic            flush = 1'b0;

    always #10 clk = ~clk;

    xlate_unit #(.ENTRIES(NE), .VA_W(VA_W), .PPN_W(PPNW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .flush(flush)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [PAW-1:0] tb_base = '0;

    bit          m_vld [NE];
    int unsigned m_vpn [NE];
    logic [31:0] m_pte [NE];
    int          m_age [NE];

    task automatic chk(bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // table content: a pure function of base and page number
    function automatic logic [31:0] pte_of(logic [PAW-1:0] base, int unsigned vpn);
        logic [31:0] h;
        logic [31:0] v;
        v = vpn;
        h = (v * 32'h9E3779B1) ^ {2'b00, base};
        return {(v[4:3] != 2'b11), v[6:5], 9'd0, h[19:0]};
    endfunction

    function automatic int fault_of(logic [31:0] pte, int kind);
        bit ok;
        if (!pte[31]) return 1;
        case (pte[30:29])
            2'd0:    ok = (kind == 0);
            2'd1:    ok = (kind == 0) || (kind == 1);
            2'd2:    ok = (kind == 2);
            default: ok = 1'b0;
        endcase
        return ok ? 0 : 2;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 1'b0; m_vpn[i] = 0; m_pte[i] = '0; m_age[i] = i;
        end
    endfunction

    function automatic void m_inval();
        for (int i = 0; i < NE; i++) m_vld[i] = 1'b0;
    endfunction

    function automatic int m_find(int unsigned vpn);
        for (int i = 0; i < NE; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < NE; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < NE; i++) if (m_age[i] == NE - 1) return i;
        return 0;
    endfunction

    function automatic void m_touch(int idx);
        int a;
        a = m_age[idx];
        for (int i = 0; i < NE; i++) if (m_age[i] < a) m_age[i]++;
        m_age[idx] = 0;
    endfunction

    task automatic write_base(logic [PAW-1:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        tb_base = b;
        m_inval();
    endtask

    task automatic xlate(int unsigned vpn, int unsigned ofs, int kind,
                         bit fl_req, bit fl_ret, bit poke, int lat, string tag);
        int h, ef;
        logic [31:0] pte;
        logic [PAW-1:0] exp_pa;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn[21:0], ofs[9:0]};
        req_kind  = 2'(kind);
        flush     = fl_req;
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
        if (fl_req) m_inval();
        h = m_find(vpn);
        if (h >= 0) begin
            ef = fault_of(m_pte[h], kind);
            exp_pa = (ef == 0) ? {m_pte[h][19:0], ofs[9:0]} : '0;
            chk(rsp_valid == 1'b1, {tag, " R2 hit answers next cycle"}, rsp_valid, 1);
            chk(mem_rd_en == 1'b0 && busy == 1'b0, {tag, " R2 no read on hit"},
                {mem_rd_en, busy}, 0);
            chk(rsp_fault == 2'(ef), {tag, " R6 fault on hit"}, rsp_fault, ef);
            chk(rsp_paddr == exp_pa, {tag, " R1 paddr on hit"}, rsp_paddr, exp_pa);
            m_touch(h);
        end else begin
            chk(mem_rd_en == 1'b1 && rsp_valid == 1'b0 && busy == 1'b1,
                {tag, " R3 walk read issued"}, {mem_rd_en, rsp_valid, busy}, 3'b101);
            exp_pa = tb_base + PAW'(vpn) * PAW'(4);
            chk(mem_rd_addr == exp_pa, {tag, " R3 table address"}, mem_rd_addr, exp_pa);
            pte = pte_of(tb_base, vpn);
            if (poke) begin
                req_valid = 1'b1;
                req_vaddr = ~req_vaddr;
            end
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                chk(busy == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0,
                    {tag, " R12 quiet while busy"}, {busy, rsp_valid, mem_rd_en}, 3'b100);
            end
            mem_rd_valid = 1'b1;
            mem_rd_data  = pte;
            flush        = fl_ret;
            @(negedge clk);
            mem_rd_valid = 1'b0;
            flush        = 1'b0;
            req_valid    = 1'b0;
            ef = fault_of(pte, kind);
            exp_pa = (ef == 0) ? {pte[19:0], ofs[9:0]} : '0;
            chk(rsp_valid == 1'b1 && busy == 1'b0 && mem_rd_en == 1'b0,
                {tag, " R3 response after read data"}, {rsp_valid, busy, mem_rd_en}, 3'b100);
            chk(rsp_fault == 2'(ef), {tag, " R4 R5 R6 walk fault"}, rsp_fault, ef);
            chk(rsp_paddr == exp_pa, {tag, " R1 R4 walk paddr"}, rsp_paddr, exp_pa);
            if (fl_ret) m_inval();
            if (ef == 0 && !fl_ret) begin
                h = m_victim();
                m_vld[h] = 1'b1; m_vpn[h] = vpn; m_pte[h] = pte;
                m_touch(h);
            end
        end
        if (poke) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0 && mem_rd_en == 1'b0 && busy == 1'b0,
                {tag, " R12 request during walk ignored"}, {rsp_valid, mem_rd_en, busy}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20250419));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && rsp_valid == 0 && mem_rd_en == 0, "R11 reset outputs",
            {busy, rsp_valid, mem_rd_en}, 0);

        // R11 base 0, empty cache; R7 install then hit; R1 offsets
        xlate(32'h100, 10'h3FF, 0, 0, 0, 0, 1, "R11");
        xlate(32'h100, 10'h000, 0, 0, 0, 0, 1, "R7");
        xlate(32'h100, 10'h2A5, 0, 0, 0, 0, 1, "R1");
        // R5 page fault, not installed
        xlate(32'h118, 10'h011, 0, 0, 0, 0, 2, "R5");
        xlate(32'h118, 10'h011, 0, 0, 0, 0, 1, "R5 rewalk");
        // R6 permissions
        xlate(32'h100, 10'h004, 1, 0, 0, 0, 1, "R6 store on RO hit");
        xlate(32'h140, 10'h008, 0, 0, 0, 0, 3, "R6 load on exec");
        xlate(32'h140, 10'h008, 2, 0, 0, 0, 1, "R6 fetch on exec");
        xlate(32'h140, 10'h00C, 1, 0, 0, 0, 1, "R6 store on exec hit");
        xlate(32'h160, 10'h010, 2, 0, 0, 0, 1, "R6 no access");
        xlate(32'h120, 10'h014, 1, 0, 0, 0, 1, "R6 store on RW");
        // R9 base write
        write_base(30'h0012_3450);
        xlate(32'h100, 10'h021, 0, 0, 0, 0, 2, "R9 new base");
        // R10 flush with request, flush with returning data
        xlate(32'h100, 10'h022, 0, 1, 0, 0, 1, "R10 flush with lookup");
        xlate(32'h120, 10'h023, 0, 0, 1, 0, 2, "R10 flush with return");
        xlate(32'h120, 10'h024, 0, 0, 0, 0, 1, "R10 not installed");
        // R12 request while busy
        xlate(32'h128, 10'h025, 0, 0, 0, 1, 3, "R12");
        // R8 replacement order
        xlate(32'h300, 10'h001, 0, 1, 0, 0, 1, "R8 fill");
        for (int i = 1; i < NE; i++) xlate(32'h300 + i, 10'h001, 0, 0, 0, 0, 1, "R8 fill");
        xlate(32'h300, 10'h002, 0, 0, 0, 0, 1, "R8 touch");
        xlate(32'h380, 10'h003, 0, 0, 0, 0, 1, "R8 evict");
        xlate(32'h301, 10'h004, 0, 0, 0, 0, 1, "R8 evicted walks");
        xlate(32'h300, 10'h005, 0, 0, 0, 0, 1, "R8 kept hits");

        // random mix over a small page pool
        for (int n = 0; n < 400; n++) begin
            int unsigned vpn;
            vpn = 32'h40 + ($urandom % 12) * 8;
            if ($urandom % 40 == 0) write_base(PAW'($urandom) & 30'h00FF_FFFC);
            xlate(vpn, $urandom % 1024, $urandom % 3, ($urandom % 16) == 0,
                  ($urandom % 16) == 0, ($urandom % 8) == 0, 1 + $urandom % 3, "RND");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule